// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software progress. A 12-bit down counter is loaded with a programmable reload value. It steps once every 128 pulses of a slow-tick enable input. If software fails to refresh the counter before it runs out, the block flags an underflow. If software refreshes while the count is still above a programmable window limit, the block flags an error. The early-refresh check catches code stuck in a tight loop that keeps refreshing.

Software reaches the block through three registers on a single-cycle register port. The mode register can be written only once after reset. A control register accepts a refresh only when the write carries the key. A status register clears itself when read. The block raises a fault request towards the reset controller and an interrupt line. Debug and idle inputs can freeze the count when the matching halt bits are set.

Register map (addr_i): 0 = mode, 1 = control, 2 = status. Reads of any other address return zero.

Top module: `win_wdog`

## Requirements
- R1: After reset, the mode register reads 0x0FFF2FFF: reload value 0xFFF, window limit 0xFFF, fault-reset enable set, all other bits clear. The status register reads 0, and fault_o and irq_o are low.
- R2: Once restarted with reload value V, the counter underflows on exactly the (V+1)*128-th counted tick. The underflow sets status bit 0.
- R3: Only the first mode write after reset is taken. That write reloads the counter and restarts the prescaler. Later mode writes change neither the readback nor the count. Mode fields are: reload [11:0], interrupt enable bit 12, fault-reset enable bit 13, disable bit 15, window limit [27:16], debug-halt bit 28, idle-halt bit 29.
- R4: A control write with 0xA5 in bits [31:24] and bit 0 set is a refresh. It reloads the counter and restarts the prescaler. A control write with any other key has no effect.
- R5: A refresh while the count is above the window limit sets status bit 1 and asserts fault_o, even when the watchdog is disabled. It does not reload the counter. A refresh with the count at or below the limit reloads normally.
- R6: When the window limit is at least the reload value, a refresh at any count is accepted without error.
- R7: An underflow asserts fault_o only while the fault-reset enable is set.
- R8: irq_o is high while either status flag is set and the interrupt enable is set.
- R9: Reading the status register clears both flags, so irq_o and fault_o fall after that cycle.
- R10: Ticks are not counted while dbg_i is high with debug-halt set, or while idle_i is high with idle-halt set.
- R11: With the disable bit set, the counter does not move and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle slow-clock enable |
| dbg_i | input | 1 | Processor in debug state |
| idle_i | input | 1 | Processor idle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a status read clears the flags) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| fault_o | output | 1 | Fault request to the reset controller |
| irq_o | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach: an underflow at its exact cycle, and proof that an ignored write did not quietly restart the count. The counter is not visible at the ports. Both therefore rest on tick arithmetic: the bench spends part of the (V+1)*128 budget, issues a rejected mode write or a bad-key refresh, spends the rest, and checks that the fault appears on the last tick and not one tick before. The window error is reached by a small reload value and a lower limit, with a refresh placed right after the mode write and again after exactly enough steps to land on the limit.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  localparam int CNT_W = 12;
  localparam int KEY_W = 8;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam logic [KEY_W-1:0] REFRESH_KEY = 8'hA5;

  typedef struct packed {
    logic [1:0]       rsv_hi;
    logic             idle_halt;
    logic             dbg_halt;
    logic [CNT_W-1:0] wdd;
    logic             dis;
    logic             rsv_mid;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] wdv;
  } mode_t;

  localparam mode_t MODE_RST = '{
    rsv_hi:    2'b00,
    idle_halt: 1'b0,
    dbg_halt:  1'b0,
    wdd:       {CNT_W{1'b1}},
    dis:       1'b0,
    rsv_mid:   1'b0,
    rst_en:    1'b1,
    irq_en:    1'b0,
    wdv:       {CNT_W{1'b1}}
  };
endpackage

// File: rtl/win_wdog_presc.sv
module win_wdog_presc #(
  parameter int DIV_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic step_o
);
  logic [DIV_W-1:0] div_q;

  assign step_o = run_i & tick_i & ~clr_i & (&div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (clr_i)          div_q <= '0;
    else if (run_i && tick_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/win_wdog_cnt.sv
module win_wdog_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         unf_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign unf_o = step_i & ~load_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '1;
    else if (load_i)       cnt_q <= load_val_i;
    else if (step_i) begin
      if (cnt_q == '0)     cnt_q <= load_val_i;  // reload after underflow
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/win_wdog_regs.sv
module win_wdog_regs
  import win_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             unf_evt_i,
  output mode_t            mode_o,
  output logic             lock_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             unf_o,
  output logic             err_o,
  output logic [31:0]      rdata_o
);
  mode_t mode_q, new_mode;
  logic  lock_q, unf_q, err_q;
  logic  mode_wr, ctrl_hit, early, stat_rd;

  always_comb begin
    new_mode         = mode_t'(wdata_i);
    new_mode.rsv_hi  = '0;
    new_mode.rsv_mid = 1'b0;
  end

  assign mode_wr  = wr_en_i && (addr_i == ADDR_MODE) && !lock_q;
  assign ctrl_hit = wr_en_i && (addr_i == ADDR_CTRL)
                    && (wdata_i[31 -: KEY_W] == REFRESH_KEY) && wdata_i[0];
  assign early    = ctrl_hit && (cnt_i > mode_q.wdd);
  assign stat_rd  = rd_en_i && (addr_i == ADDR_STAT);

  assign load_o     = mode_wr | (ctrl_hit & ~early);
  assign load_val_o = mode_wr ? new_mode.wdv : mode_q.wdv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      lock_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= new_mode;
      lock_q <= 1'b1;
    end
  end

  // a new event in the read cycle wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unf_q <= unf_evt_i | (unf_q & ~stat_rd);
      err_q <= early     | (err_q & ~stat_rd);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_MODE: rdata_o = mode_q;
      ADDR_STAT: rdata_o = {30'd0, err_q, unf_q};
      default:   rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign lock_o = lock_q;
  assign unf_o  = unf_q;
  assign err_o  = err_q;
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        dbg_i,
  input  logic        idle_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        fault_o,
  output logic        irq_o
);
  mode_t            mode_q;
  logic             mode_lock;
  logic             load, step, unf_evt, unf_flag, err_flag, halt, run;
  logic [CNT_W-1:0] load_val, cnt_q;

  assign halt = (dbg_i & mode_q.dbg_halt) | (idle_i & mode_q.idle_halt);
  assign run  = ~mode_q.dis & ~halt;

  win_wdog_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .unf_evt_i  (unf_evt),
    .mode_o     (mode_q),
    .lock_o     (mode_lock),
    .load_o     (load),
    .load_val_o (load_val),
    .unf_o      (unf_flag),
    .err_o      (err_flag),
    .rdata_o    (rdata_o)
  );

  win_wdog_presc #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .run_i  (run),
    .tick_i (tick_i),
    .step_o (step)
  );

  win_wdog_cnt #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (step),
    .cnt_o      (cnt_q),
    .unf_o      (unf_evt)
  );

  assign fault_o = err_flag | (unf_flag & mode_q.rst_en);
  assign irq_o   = (err_flag | unf_flag) & mode_q.irq_en;
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk
  import win_wdog_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             dbg_i,
  input logic             idle_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [1:0]       addr_i,
  input logic [KEY_W-1:0] key_i,
  input logic             restart_bit_i,
  input logic             fault_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_i,
  input mode_t            mode_i,
  input logic             lock_i,
  input logic             unf_i,
  input logic             err_i
);
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= mode_i.wdv);

  a_r3_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(mode_i));

  a_r5_early_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL && key_i == REFRESH_KEY && restart_bit_i
     && cnt_i > mode_i.wdd) |=> (fault_o && err_i));

  a_r7_fault_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !err_i) |-> mode_i.rst_en);

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_STAT && !wr_en_i && !tick_i) |=> (!fault_o && !irq_o));

  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((dbg_i && mode_i.dbg_halt) || (idle_i && mode_i.idle_halt)) && !wr_en_i)
    |=> $stable(cnt_i));

  a_r11_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.dis && !wr_en_i) |=> ($stable(cnt_i) && !$rose(unf_i)));
endmodule

bind win_wdog win_wdog_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .dbg_i         (dbg_i),
  .idle_i        (idle_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .addr_i        (addr_i),
  .key_i         (wdata_i[31:24]),
  .restart_bit_i (wdata_i[0]),
  .fault_o       (fault_o),
  .irq_o         (irq_o),
  .cnt_i         (cnt_q),
  .mode_i        (mode_q),
  .lock_i        (mode_lock),
  .unf_i         (unf_flag),
  .err_i         (err_flag)
);

// File: tb/tb_win_wdog.sv
`timescale 1ns/1ps
module tb_win_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, dbg = 1'b0, idle = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fault, irq;
  int          n_chk = 0, n_fail = 0;

  localparam logic [31:0] GOOD_REF = 32'hA500_0001;
  localparam logic [31:0] BAD_REF  = 32'h5A00_0001;

  always #2 clk = ~clk;

  win_wdog dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dbg_i(dbg), .idle_i(idle),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .fault_o(fault), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    dbg = 1'b0; idle = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk) tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(2'd0, d); check("R1 mode reset", d, 32'h0FFF_2FFF);
    rd(2'd2, d); check("R1 status reset", d, 0);
    check("R1 fault/irq reset", {fault, irq}, 0);
  endtask

  task automatic t_default_window();
    logic [31:0] d;
    do_reset();
    wr(2'd1, GOOD_REF);
    rd(2'd2, d); check("R6 refresh at 0xFFF accepted", d, 0);
    check("R6 no fault", fault, 0);
  endtask

  task automatic t_period_once();
    logic [31:0] d;
    do_reset();
    wr(2'd0, 32'h0000_2003);
    run(300);
    wr(2'd0, 32'h0000_20FF);
    rd(2'd0, d); check("R3 second mode write ignored", d, 32'h0000_2003);
    run(211); check("R2/R3 no underflow at 511", fault, 0);
    run(1);   check("R2/R7 underflow at 512", fault, 1);
    rd(2'd2, d); check("R2 status underflow bit", d, 1);
    check("R9 fault cleared by read", fault, 0);
  endtask

  task automatic t_keyed_refresh();
    do_reset();
    wr(2'd0, 32'h0003_2003);
    run(300);
    wr(2'd1, BAD_REF);
    run(212); check("R4 bad key ignored", fault, 1);
    do_reset();
    wr(2'd0, 32'h0003_2003);
    run(300);
    wr(2'd1, GOOD_REF);
    run(511); check("R4 refresh restarted count", fault, 0);
    run(1);   check("R4 underflow after refresh", fault, 1);
  endtask

  task automatic t_window();
    logic [31:0] d;
    do_reset();
    wr(2'd0, 32'h0005_100A);
    wr(2'd1, GOOD_REF);
    check("R5 early refresh fault", fault, 1);
    check("R8 irq on error", irq, 1);
    rd(2'd2, d); check("R5 error bit", d, 2);
    check("R9 irq/fault cleared", {fault, irq}, 0);
    run(640);
    wr(2'd1, GOOD_REF);
    check("R5 refresh at limit accepted", fault, 0);
    run(1407); check("R8 no irq before underflow", irq, 0);
    run(1);    check("R8 irq on underflow", irq, 1);
    check("R7 no fault with reset disabled", fault, 0);
    rd(2'd2, d); check("R5 in-window refresh reloaded", d, 1);
  endtask

  task automatic t_halt();
    do_reset();
    wr(2'd0, 32'h1001_2001);
    run(100);
    dbg = 1'b1; run(1000); dbg = 1'b0;
    idle = 1'b1; run(155);
    check("R10 debug halt froze count", fault, 0);
    run(1); check("R10 idle not halted without bit", fault, 1);
    idle = 1'b0;
    do_reset();
    wr(2'd0, 32'h2001_2001);
    idle = 1'b1; run(1000); idle = 1'b0;
    check("R10 idle halt froze count", fault, 0);
    run(255); check("R10 resume count", fault, 0);
    run(1);   check("R10 underflow after idle", fault, 1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    do_reset();
    wr(2'd0, 32'h0002_A005);
    run(2000);
    check("R11 disabled no fault", fault, 0);
    rd(2'd2, d); check("R11 disabled no underflow", d, 0);
    wr(2'd1, GOOD_REF);
    check("R5 early refresh while disabled", fault, 1);
    rd(2'd2, d); check("R5 error bit while disabled", d, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_default_window();
    t_period_once();
    t_keyed_refresh();
    t_window();
    t_halt();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule